// File: doc/BRIEF.md
# Paired-Block UART Interrupt Status and Mask Controller

This block keeps the interrupt state of an eight-channel UART that is organised as four blocks of two channels. Each block owns an 8-bit status register, set and cleared by one-cycle strobes from the channel units (transmit ready, receive ready, break), and an 8-bit mask register written by the host. The blocks are combined in pairs onto two active-high interrupt lines. Blocks 0 and 1 drive line 0, and blocks 2 and 3 drive line 1.

The host reaches the status and mask registers through a byte-addressed register space. Each block has a 32-byte window. Inside a window the register offset is the low five address bits with bit 0 inverted. The status register is read and the mask register is written at offset 0x0B, so its byte address is `block*32 + 0x0A`.

A separate identification space holds a programmable 8-bit vector, written at address 1. An interrupt-acknowledge space returns that vector for reads at address 0 (line 0) or address 2 (line 1). The read data ports and the interrupt lines are combinational views of the registers. Any register change is therefore visible in the cycle after the clock edge that stores it.

Top module: `uart_irq_ctrl`

## Requirements
- R1: After reset all status, mask and vector registers are zero, both interrupt lines are low, and every read returns zero.
- R2: For an even channel c, the strobes affect block c/2 of the status register as follows: transmit ready sets or clears bit 0, receive ready bit 1, and break bit 2.
- R3: For an odd channel c, the strobes affect block c/2 of the status register as follows: transmit ready sets or clears bit 4, receive ready bit 5, and break bit 6.
- R4: When a set strobe and a clear strobe reach the same status bit in one cycle, the bit becomes 1. A clear strobe alone makes the bit 0, and with no strobe the bit holds its value.
- R5: A host read with io_addr_i[7]=0 and io_addr_i[4:0]=0x0A returns the status register of block io_addr_i[6:5]. Every other read address returns zero.
- R6: A host write at the same address loads the mask register of block io_addr_i[6:5] and leaves the status register unchanged. Writes at other offsets, and writes with io_addr_i[7]=1, change no mask.
- R7: irq_o[k] is high exactly when (status AND mask) is nonzero in block 2k or in block 2k+1. It follows any status or mask change in the next cycle.
- R8: Pending status from either block of a pair raises only that pair's line. Status bits whose mask bit is zero do not raise any line.
- R9: An acknowledge read at address 0 or address 2 returns the stored vector. An acknowledge read at any other address returns zero. Acknowledge reads change no state.
- R10: An identification-space write at address 1 stores io_wdata_i-style data from id_wdata_i as the vector. Writes at other identification addresses do not change the vector.
- R11: Status bits 3 and 7 of every block always read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| io_rd_i | input | 1 | Host register read strobe |
| io_wr_i | input | 1 | Host register write strobe |
| io_addr_i | input | 8 | Host register byte address |
| io_wdata_i | input | 8 | Host register write data |
| io_rdata_o | output | 8 | Host register read data |
| id_wr_i | input | 1 | Identification-space write strobe |
| id_addr_i | input | 8 | Identification-space address |
| id_wdata_i | input | 8 | Identification-space write data |
| ack_rd_i | input | 1 | Interrupt-acknowledge read strobe |
| ack_addr_i | input | 8 | Interrupt-acknowledge address |
| ack_data_o | output | 8 | Acknowledge read data (vector) |
| tx_set_i | input | 8 | Per-channel transmit-ready set strobe |
| tx_clr_i | input | 8 | Per-channel transmit-ready clear strobe |
| rx_set_i | input | 8 | Per-channel receive-ready set strobe |
| rx_clr_i | input | 8 | Per-channel receive-ready clear strobe |
| brk_set_i | input | 8 | Per-channel break set strobe |
| brk_clr_i | input | 8 | Per-channel break clear strobe |
| irq_o | output | 2 | Interrupt lines, one per block pair, active high |

## Verification
Faults in the internal state show up at the ports in the cycle after the edge that stores it.

- A status bit in the wrong lane, or a lost set-over-clear priority, shows as a wrong status read of that block.
- A wrong mask or a miswired pair shows on irq_o in that same next cycle, often on the other line.
- A corrupted vector appears only at the next acknowledge read. For that reason every vector change is followed at once by acknowledge reads at both valid addresses and at one invalid address.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int WIN_W     = 5;        // 32-byte window per block
  localparam int STAT_OFF  = 5'h0B;    // status read / mask write offset
  localparam int LANE_W    = 4;        // status bits per channel lane
  localparam int TX_BIT    = 0;
  localparam int RX_BIT    = 1;
  localparam int BRK_BIT   = 2;
  localparam int ACK_ADDR0 = 0;
  localparam int ACK_ADDR1 = 2;
  localparam int VEC_ADDR  = 1;
endpackage

// File: rtl/irqc_addr_dec.sv
module irqc_addr_dec
  import irqc_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int NBLK   = 4,
  localparam int BLK_W = $clog2(NBLK)
) (
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [BLK_W-1:0]  blk_o,
  output logic              stat_rd_o,
  output logic              mask_we_o
);
  logic [WIN_W-1:0] off;
  logic             in_range;
  logic             hit;

  assign off      = addr_i[WIN_W-1:0] ^ WIN_W'(1);   // byte regs live at odd offsets
  assign in_range = (addr_i[ADDR_W-1:WIN_W+BLK_W] == '0);
  assign hit      = in_range && (off == WIN_W'(STAT_OFF));
  assign blk_o    = addr_i[WIN_W+BLK_W-1:WIN_W];
  assign stat_rd_o = rd_i && hit;
  assign mask_we_o = wr_i && hit;
endmodule

// File: rtl/irqc_blk.sv
module irqc_blk
  import irqc_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    tx_set_i,
  input  logic [1:0]    tx_clr_i,
  input  logic [1:0]    rx_set_i,
  input  logic [1:0]    rx_clr_i,
  input  logic [1:0]    brk_set_i,
  input  logic [1:0]    brk_clr_i,
  input  logic          mask_we_i,
  input  logic [DW-1:0] mask_d_i,
  output logic [DW-1:0] stat_o,
  output logic [DW-1:0] mask_o,
  output logic          pend_o
);
  logic [DW-1:0] stat_q, mask_q, set_v, clr_v;

  always_comb begin
    set_v = '0;
    clr_v = '0;
    for (int c = 0; c < 2; c++) begin
      set_v[c*LANE_W+TX_BIT]  = tx_set_i[c];
      set_v[c*LANE_W+RX_BIT]  = rx_set_i[c];
      set_v[c*LANE_W+BRK_BIT] = brk_set_i[c];
      clr_v[c*LANE_W+TX_BIT]  = tx_clr_i[c];
      clr_v[c*LANE_W+RX_BIT]  = rx_clr_i[c];
      clr_v[c*LANE_W+BRK_BIT] = brk_clr_i[c];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      mask_q <= '0;
    end else begin
      stat_q <= (stat_q & ~clr_v) | set_v;   // set wins
      if (mask_we_i) mask_q <= mask_d_i;
    end
  end

  assign stat_o = stat_q;
  assign mask_o = mask_q;
  assign pend_o = |(stat_q & mask_q);

  a_r4_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_v != '0) |=> ((stat_q & $past(set_v)) == $past(set_v)));
  a_r4_clear_alone: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((clr_v & ~set_v) != '0) |=> ((stat_q & $past(clr_v & ~set_v)) == '0));
  a_r4_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((set_v | clr_v) == '0) |=> $stable(stat_q));
  a_r6_mask_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_we_i |=> (mask_q == $past(mask_d_i)));
  a_r6_mask_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mask_we_i |=> $stable(mask_q));
endmodule

// File: rtl/irqc_vec.sv
module irqc_vec
  import irqc_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DW     = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              id_wr_i,
  input  logic [ADDR_W-1:0] id_addr_i,
  input  logic [DW-1:0]     id_wdata_i,
  input  logic              ack_rd_i,
  input  logic [ADDR_W-1:0] ack_addr_i,
  output logic [DW-1:0]     ack_data_o
);
  logic [DW-1:0] vec_q;
  logic          vec_we, ack_hit;

  assign vec_we  = id_wr_i && (id_addr_i == ADDR_W'(VEC_ADDR));
  assign ack_hit = ack_rd_i && ((ack_addr_i == ADDR_W'(ACK_ADDR0)) ||
                                (ack_addr_i == ADDR_W'(ACK_ADDR1)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     vec_q <= '0;
    else if (vec_we) vec_q <= id_wdata_i;
  end

  assign ack_data_o = ack_hit ? vec_q : '0;

  a_r10_vec_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (id_wr_i && id_addr_i == ADDR_W'(VEC_ADDR)) |=> (vec_q == $past(id_wdata_i)));
  a_r10_vec_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(id_wr_i && id_addr_i == ADDR_W'(VEC_ADDR)) |=> $stable(vec_q));
  a_r9_bad_ack_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_rd_i && ack_addr_i != ADDR_W'(ACK_ADDR0) && ack_addr_i != ADDR_W'(ACK_ADDR1))
      |-> (ack_data_o == '0));
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import irqc_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DW     = 8,
  parameter int NBLK   = 4,
  localparam int NCH   = 2 * NBLK,
  localparam int NLINE = NBLK / 2,
  localparam int BLK_W = $clog2(NBLK)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              io_rd_i,
  input  logic              io_wr_i,
  input  logic [ADDR_W-1:0] io_addr_i,
  input  logic [DW-1:0]     io_wdata_i,
  output logic [DW-1:0]     io_rdata_o,
  input  logic              id_wr_i,
  input  logic [ADDR_W-1:0] id_addr_i,
  input  logic [DW-1:0]     id_wdata_i,
  input  logic              ack_rd_i,
  input  logic [ADDR_W-1:0] ack_addr_i,
  output logic [DW-1:0]     ack_data_o,
  input  logic [NCH-1:0]    tx_set_i,
  input  logic [NCH-1:0]    tx_clr_i,
  input  logic [NCH-1:0]    rx_set_i,
  input  logic [NCH-1:0]    rx_clr_i,
  input  logic [NCH-1:0]    brk_set_i,
  input  logic [NCH-1:0]    brk_clr_i,
  output logic [NLINE-1:0]  irq_o
);
  logic [BLK_W-1:0] blk_sel;
  logic             stat_rd, mask_we;
  logic [DW-1:0]    stat_w [NBLK];
  logic [DW-1:0]    mask_w [NBLK];
  logic [NBLK-1:0]  pend_w;

  irqc_addr_dec #(.ADDR_W(ADDR_W), .NBLK(NBLK)) u_dec (
    .rd_i      (io_rd_i),
    .wr_i      (io_wr_i),
    .addr_i    (io_addr_i),
    .blk_o     (blk_sel),
    .stat_rd_o (stat_rd),
    .mask_we_o (mask_we)
  );

  for (genvar b = 0; b < NBLK; b++) begin : g_blk
    irqc_blk #(.DW(DW)) u_blk (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .tx_set_i  (tx_set_i[2*b+1:2*b]),
      .tx_clr_i  (tx_clr_i[2*b+1:2*b]),
      .rx_set_i  (rx_set_i[2*b+1:2*b]),
      .rx_clr_i  (rx_clr_i[2*b+1:2*b]),
      .brk_set_i (brk_set_i[2*b+1:2*b]),
      .brk_clr_i (brk_clr_i[2*b+1:2*b]),
      .mask_we_i (mask_we && (blk_sel == BLK_W'(b))),
      .mask_d_i  (io_wdata_i),
      .stat_o    (stat_w[b]),
      .mask_o    (mask_w[b]),
      .pend_o    (pend_w[b])
    );
  end

  for (genvar k = 0; k < NLINE; k++) begin : g_line
    assign irq_o[k] = pend_w[2*k] | pend_w[2*k+1];

    a_r8_line_needs_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o[k] |-> ((mask_w[2*k] | mask_w[2*k+1]) != '0));
  end

  assign io_rdata_o = stat_rd ? stat_w[blk_sel] : '0;

  irqc_vec #(.ADDR_W(ADDR_W), .DW(DW)) u_vec (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .id_wr_i    (id_wr_i),
    .id_addr_i  (id_addr_i),
    .id_wdata_i (id_wdata_i),
    .ack_rd_i   (ack_rd_i),
    .ack_addr_i (ack_addr_i),
    .ack_data_o (ack_data_o)
  );

  a_r5_idle_read_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !io_rd_i |-> (io_rdata_o == '0));
endmodule

// File: tb/uart_irq_ctrl_test.sv
module uart_irq_ctrl_test;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    string      tag;
    logic [7:0] rd;
    logic [7:0] ack;
    logic [1:0] irq;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       io_rd = 1'b0, io_wr = 1'b0;
  logic [7:0] io_addr = '0, io_wdata = '0, io_rdata;
  logic       id_wr = 1'b0;
  logic [7:0] id_addr = '0, id_wdata = '0;
  logic       ack_rd = 1'b0;
  logic [7:0] ack_addr = '0, ack_data;
  logic [7:0] tx_s = '0, tx_c = '0, rx_s = '0, rx_c = '0, bk_s = '0, bk_c = '0;
  logic [1:0] irq;

  logic [7:0] stat_m [4];
  logic [7:0] mask_m [4];
  logic [7:0] vec_m;
  exp_t       q[$];
  int         checks = 0, errors = 0;
  bit         done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_irq_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n),
    .io_rd_i(io_rd), .io_wr_i(io_wr), .io_addr_i(io_addr),
    .io_wdata_i(io_wdata), .io_rdata_o(io_rdata),
    .id_wr_i(id_wr), .id_addr_i(id_addr), .id_wdata_i(id_wdata),
    .ack_rd_i(ack_rd), .ack_addr_i(ack_addr), .ack_data_o(ack_data),
    .tx_set_i(tx_s), .tx_clr_i(tx_c), .rx_set_i(rx_s), .rx_clr_i(rx_c),
    .brk_set_i(bk_s), .brk_clr_i(bk_c), .irq_o(irq)
  );

  task automatic idle();
    io_rd = 0; io_wr = 0; id_wr = 0; ack_rd = 0;
    tx_s = '0; tx_c = '0; rx_s = '0; rx_c = '0; bk_s = '0; bk_c = '0;
  endtask

  // Per channel: even -> bits 0..2, odd -> bits 4..6 of block ch/2; set wins.
  task automatic strobe(input logic [7:0] ts, tc, rs, rc, bs, bc);
    @(negedge clk); idle();
    tx_s = ts; tx_c = tc; rx_s = rs; rx_c = rc; bk_s = bs; bk_c = bc;
    for (int c = 0; c < 8; c++) begin
      int b = c / 2;
      int o = (c % 2) * 4;
      if (tc[c]) stat_m[b][o]   = 1'b0;
      if (rc[c]) stat_m[b][o+1] = 1'b0;
      if (bc[c]) stat_m[b][o+2] = 1'b0;
      if (ts[c]) stat_m[b][o]   = 1'b1;
      if (rs[c]) stat_m[b][o+1] = 1'b1;
      if (bs[c]) stat_m[b][o+2] = 1'b1;
    end
  endtask

  task automatic host_wr(input logic [7:0] a, d);
    @(negedge clk); idle();
    io_wr = 1; io_addr = a; io_wdata = d;
    if (!a[7] && a[4:0] == 5'h0A) mask_m[a[6:5]] = d;
  endtask

  task automatic id_write(input logic [7:0] a, d);
    @(negedge clk); idle();
    id_wr = 1; id_addr = a; id_wdata = d;
    if (a == 8'd1) vec_m = d;
  endtask

  // One observation cycle: drive reads, push expectation for the monitor.
  task automatic observe(input logic [7:0] ra, input logic [7:0] aa, input string tag);
    exp_t e;
    @(negedge clk); idle();
    io_rd = 1; io_addr = ra; ack_rd = 1; ack_addr = aa;
    e.tag = tag;
    e.rd  = (!ra[7] && ra[4:0] == 5'h0A) ? stat_m[ra[6:5]] : 8'h00;
    e.ack = (aa == 8'd0 || aa == 8'd2) ? vec_m : 8'h00;
    for (int k = 0; k < 2; k++)
      e.irq[k] = ((stat_m[2*k] & mask_m[2*k]) != 0) || ((stat_m[2*k+1] & mask_m[2*k+1]) != 0);
    q.push_back(e);
  endtask

  function automatic logic [7:0] sa(input int b);
    return 8'(b * 32 + 8'h0A);
  endfunction

  // Monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      #3;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (io_rdata !== e.rd || ack_data !== e.ack || irq !== e.irq) begin
          errors++;
          $display("FAIL %s: rd=%h ack=%h irq=%b expected rd=%h ack=%h irq=%b",
                   e.tag, io_rdata, ack_data, irq, e.rd, e.ack, e.irq);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int b = 0; b < 4; b++) begin stat_m[b] = '0; mask_m[b] = '0; end
    vec_m = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1: reset state
    for (int b = 0; b < 4; b++) observe(sa(b), 8'd0, "R1 reset status/vector");
    observe(sa(0), 8'd2, "R1 reset ack line 1");

    // R2: even channel lanes
    strobe(8'h01, 0, 0, 0, 0, 0);
    observe(sa(0), 8'd5, "R2 ch0 tx -> bit0");
    strobe(0, 0, 8'h04, 0, 8'h04, 0);
    observe(sa(1), 8'd5, "R2 ch2 rx+brk -> bits1,2");
    // R3: odd channel lanes
    strobe(0, 0, 8'h02, 0, 0, 0);
    observe(sa(0), 8'd5, "R3 ch1 rx -> bit5");
    strobe(0, 0, 0, 0, 8'h20, 0);
    observe(sa(2), 8'd5, "R3 ch5 brk -> bit6");
    strobe(8'h80, 0, 8'h40, 0, 0, 0);
    observe(sa(3), 8'd5, "R3 ch7 tx bit4, ch6 rx bit1");
    // R11: bits 3 and 7 never set (all strobes on block 1)
    strobe(8'h0C, 0, 8'h0C, 0, 8'h0C, 0);
    observe(sa(1), 8'd5, "R11 block1 all lanes, bits3/7 zero");

    // R6/R7: mask write, status unchanged, line follows
    host_wr(sa(0), 8'h01);
    observe(sa(0), 8'd5, "R6 mask write keeps status, R7 irq0");
    // R8: block 1 pending raises line 0 only
    host_wr(sa(0), 8'h00);
    host_wr(sa(1), 8'h40);
    observe(sa(1), 8'd5, "R8 block1 -> line0 only");
    host_wr(sa(1), 8'h88);
    observe(sa(1), 8'd5, "R8 unmasked-only bits no irq");
    // R7: block 2 on line 1
    host_wr(sa(2), 8'h40);
    observe(sa(2), 8'd5, "R7 block2 -> line1");
    // R4: clear alone drops bit, line follows
    strobe(0, 0, 0, 0, 0, 8'h20);
    observe(sa(2), 8'd5, "R4 clear alone, R7 irq1 falls");
    // R4: set and clear same cycle -> set wins
    strobe(8'h10, 8'h10, 0, 0, 8'h20, 8'h20);
    observe(sa(2), 8'd5, "R4 set wins over clear");
    // R4: hold with no strobes
    observe(sa(2), 8'd5, "R4 hold");
    strobe(0, 8'hFF, 0, 8'hFF, 0, 8'hFF);
    observe(sa(3), 8'd5, "R4 clear all");

    // R5/R6: other offsets and out-of-range addresses
    strobe(8'h01, 0, 0, 0, 0, 0);
    host_wr(sa(0), 8'h01);
    observe(8'h0B, 8'd5, "R5 other offset reads zero");
    observe(8'h8A, 8'd5, "R5 addr bit7 reads zero");
    host_wr(8'h0C, 8'h00);
    observe(sa(0), 8'd5, "R6 other offset write ignored");
    host_wr(8'h8A, 8'h00);
    observe(sa(0), 8'd5, "R6 addr bit7 write ignored");

    // R9/R10: vector
    id_write(8'd0, 8'h3C);
    observe(sa(0), 8'd0, "R10 id addr0 ignored");
    id_write(8'd1, 8'hA5);
    observe(sa(0), 8'd0, "R9 ack line0 vector");
    observe(sa(0), 8'd2, "R9 ack line1 vector");
    observe(sa(0), 8'd1, "R9 ack addr1 zero");
    observe(sa(0), 8'd3, "R9 ack addr3 zero");
    id_write(8'd3, 8'h11);
    observe(sa(0), 8'd2, "R10 id addr3 ignored");
    observe(sa(0), 8'd0, "R9 ack no side effect");

    @(negedge clk); idle();
    while (q.size() > 0) @(negedge clk);
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule